// File: doc/BRIEF.md
# Speculative Reorder Buffer

This block keeps the in-flight instructions of a speculative out-of-order core in program order. An issue stage asks it for a slot for each new instruction and gets back a small entry tag. That tag names the instruction's result for the rest of its life. Execution units finish in any order and broadcast a value together with its tag. The buffer files the value in the matching entry and marks the entry complete. From then on, any later instruction that names the tag can read the value through the lookup port, until the entry retires.

Retirement happens only at the oldest entry, and only once that entry is complete. A register operation emits a register-file write and a store emits a memory write. A branch that was predicted correctly just leaves. A branch flagged as mispredicted leaves and throws away everything issued after it. An instruction that faulted is never retired: its fault is kept in the entry until the entry becomes the oldest. Then the buffer reports the fault and clears every entry, so exceptions are precise.

There are eight entries with 3-bit tags, and an occupancy counter tells full apart from empty. Commit and flush results are registered and appear one clock after the deciding edge.

Top module: `spec_rob`

## Requirements
- R1: After reset the buffer is empty: `alloc_ready` is 1, `alloc_tag` is 0, `cm_valid` and `flush_valid` are 0, and a lookup returns `lk_valid` = 0.
- R2: Each accepted allocation (`alloc_valid` and `alloc_ready` high at a clock edge) takes the tag shown on `alloc_tag`. Tags are handed out in ascending order and wrap from 7 to 0.
- R3: With 8 entries outstanding, `alloc_ready` is 0. An allocation offered while `alloc_ready` is 0 is ignored and does not move the next tag.
- R4: A result broadcast (`res_valid`) stores `res_value` into the live entry named by `res_tag` and marks it complete. A broadcast to a tag that holds no live entry has no effect.
- R5: A lookup of a live, complete entry returns `lk_valid` = 1 with its stored value. A lookup of a pending, retired or discarded entry returns `lk_valid` = 0.
- R6: A broadcast in the same cycle as a lookup of the same live tag is forwarded: `lk_valid` = 1 and `lk_value` = `res_value` in that cycle.
- R7: Entries retire strictly in allocation order, at most one per clock, and only when the oldest entry is complete. Results may arrive in any order. Retirement is reported the cycle after the deciding edge, with `cm_valid` = 1 and `cm_tag` set to the tag.
- R8: The operation kind is given at allocation as 0 = register operation, 1 = store, 2 = branch. A retiring register operation raises `cm_reg_we` with `cm_dest` = register index and `cm_data` = value. A store raises `cm_st_we` with `cm_dest` = address and `cm_data` = value. A correct branch raises neither.
- R9: Allocation and retirement may happen at the same edge, and the occupancy then stays the same.
- R10: A mispredicted branch at the head (`res_mispred` set on its result) retires with `cm_valid` = 1 and, in the same cycle, `flush_valid` = 1, `flush_exc` = 0 and `flush_pc` = the branch PC. All younger entries are discarded, and the next tag is the branch tag plus one.
- R11: A faulted entry (`res_exc` = 1, cause on `res_cause`) at the head is not retired and writes nothing. The block raises `flush_valid` = 1 and `flush_exc` = 1, with `flush_pc` = its PC and `flush_cause` = its cause. It discards all entries, and the next tag is the faulting tag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| alloc_valid | input | 1 | Issue stage requests an entry |
| alloc_kind | input | 2 | Kind: 0 register op, 1 store, 2 branch |
| alloc_dest | input | 16 | Register index or store address |
| alloc_pc | input | 32 | PC of the issuing instruction |
| alloc_ready | output | 1 | An entry can be taken this cycle |
| alloc_tag | output | 3 | Tag given to the instruction being issued |
| res_valid | input | 1 | Result broadcast strobe |
| res_tag | input | 3 | Tag of the finishing entry |
| res_value | input | 32 | Result value |
| res_exc | input | 1 | The instruction faulted |
| res_cause | input | 4 | Fault cause |
| res_mispred | input | 1 | Branch resolved against its prediction |
| lk_tag | input | 3 | Tag to look up |
| lk_valid | output | 1 | The looked-up value is available |
| lk_value | output | 32 | Looked-up value |
| cm_valid | output | 1 | An entry retired |
| cm_reg_we | output | 1 | Register-file write |
| cm_st_we | output | 1 | Memory write |
| cm_tag | output | 3 | Tag of the retired entry |
| cm_dest | output | 16 | Register index or address of the write |
| cm_data | output | 32 | Data of the write |
| flush_valid | output | 1 | Younger entries were discarded |
| flush_exc | output | 1 | The flush came from a fault |
| flush_pc | output | 32 | PC of the entry that caused the flush |
| flush_cause | output | 4 | Fault cause (0 for a branch flush) |

## Verification
Allocation and retirement can meet at one clock edge. That edge must push at the tail and pop at the head while leaving the occupancy unchanged. The bench provokes this by filling all eight entries and completing them all. It then offers new instructions on the edges where the oldest entries retire. It judges the outcome by the tags handed out and by how many further allocations are accepted before `alloc_ready` falls. A second overlap, a broadcast meeting a lookup of the same tag, is judged by sampling the lookup response in that same cycle.

// File: rtl/spec_rob_pkg.sv
package spec_rob_pkg;
  typedef enum logic [1:0] {
    K_REG    = 2'd0,
    K_STORE  = 2'd1,
    K_BRANCH = 2'd2
  } op_kind_e;
endpackage

// File: rtl/rob_ptrs.sv
module rob_ptrs #(
  parameter int DEPTH = 8,
  localparam int TW   = $clog2(DEPTH),
  localparam int CNTW = $clog2(DEPTH + 1)
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            push,
  input  logic            pop,
  input  logic            flush_keep,
  input  logic            flush_all,
  output logic [TW-1:0]   head,
  output logic [TW-1:0]   tail,
  output logic [CNTW-1:0] count,
  output logic            full
);
  logic [TW-1:0]   head_q, tail_q;
  logic [CNTW-1:0] count_q;

  function automatic logic [TW-1:0] nxt(input logic [TW-1:0] p);
    return (p == TW'(DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  always_ff @(posedge clk) begin
    if (rst) begin
      head_q  <= '0;
      tail_q  <= '0;
      count_q <= '0;
    end else if (flush_all) begin
      tail_q  <= head_q;
      count_q <= '0;
    end else if (flush_keep) begin
      head_q  <= nxt(head_q);
      tail_q  <= nxt(head_q);
      count_q <= '0;
    end else begin
      if (push) tail_q <= nxt(tail_q);
      if (pop)  head_q <= nxt(head_q);
      count_q <= count_q + CNTW'(push) - CNTW'(pop);
    end
  end

  assign head  = head_q;
  assign tail  = tail_q;
  assign count = count_q;
  assign full  = (count_q == CNTW'(DEPTH));

  p_reset_empty_r1: assert property (@(posedge clk) disable iff (rst)
    $fell(rst) |-> (count_q == '0 && head_q == tail_q));

  p_no_overflow_r3: assert property (@(posedge clk) disable iff (rst)
    (full && !flush_keep && !flush_all) |=> (tail_q == $past(tail_q)));
endmodule

// File: rtl/rob_store.sv
module rob_store #(
  parameter int DEPTH = 8,
  parameter int DW    = 32,
  parameter int AW    = 16,
  parameter int PCW   = 32,
  parameter int CW    = 4,
  localparam int TW   = $clog2(DEPTH)
) (
  input  logic           clk,
  input  logic           rst,
  input  logic           alloc_we,
  input  logic [TW-1:0]  alloc_idx,
  input  logic [1:0]     alloc_kind,
  input  logic [AW-1:0]  alloc_dest,
  input  logic [PCW-1:0] alloc_pc,
  input  logic           res_valid,
  input  logic [TW-1:0]  res_tag,
  input  logic [DW-1:0]  res_value,
  input  logic           res_exc,
  input  logic [CW-1:0]  res_cause,
  input  logic           res_mispred,
  input  logic           kill_all,
  input  logic           free_we,
  input  logic [TW-1:0]  head_idx,
  input  logic [TW-1:0]  lk_tag,
  output logic           lk_valid,
  output logic [DW-1:0]  lk_value,
  output logic           head_live,
  output logic           head_done,
  output logic [1:0]     head_kind,
  output logic [AW-1:0]  head_dest,
  output logic [PCW-1:0] head_pc,
  output logic [DW-1:0]  head_value,
  output logic           head_exc,
  output logic [CW-1:0]  head_cause,
  output logic           head_mispred
);
  logic [DEPTH-1:0] live_v, done_v, exc_v, misp_v;
  logic             res_hit;

  logic [DW-1:0]  value_mem [DEPTH];
  logic [CW-1:0]  cause_mem [DEPTH];
  logic [1:0]     kind_mem  [DEPTH];
  logic [AW-1:0]  dest_mem  [DEPTH];
  logic [PCW-1:0] pc_mem    [DEPTH];

  assign res_hit = res_valid && live_v[res_tag];

  for (genvar i = 0; i < DEPTH; i++) begin : g_ent
    logic live_r, done_r, exc_r, misp_r;
    always_ff @(posedge clk) begin
      if (rst) begin
        live_r <= 1'b0;
        done_r <= 1'b0;
        exc_r  <= 1'b0;
        misp_r <= 1'b0;
      end else begin
        if (kill_all)
          live_r <= 1'b0;
        else if (alloc_we && alloc_idx == TW'(i))
          live_r <= 1'b1;
        else if (free_we && head_idx == TW'(i))
          live_r <= 1'b0;
        if (alloc_we && alloc_idx == TW'(i)) begin
          done_r <= 1'b0;
          exc_r  <= 1'b0;
          misp_r <= 1'b0;
        end else if (res_hit && res_tag == TW'(i)) begin
          done_r <= 1'b1;
          exc_r  <= res_exc;
          misp_r <= res_mispred;
        end
      end
    end
    assign live_v[i] = live_r;
    assign done_v[i] = done_r;
    assign exc_v[i]  = exc_r;
    assign misp_v[i] = misp_r;
  end

  always_ff @(posedge clk) begin
    if (res_hit) begin
      value_mem[res_tag] <= res_value;
      cause_mem[res_tag] <= res_cause;
    end
  end

  always_ff @(posedge clk) begin
    if (alloc_we) begin
      kind_mem[alloc_idx] <= alloc_kind;
      dest_mem[alloc_idx] <= alloc_dest;
      pc_mem[alloc_idx]   <= alloc_pc;
    end
  end

  logic lk_bus_hit;
  assign lk_bus_hit = res_valid && (res_tag == lk_tag) && live_v[lk_tag];
  assign lk_valid   = lk_bus_hit || (live_v[lk_tag] && done_v[lk_tag]);
  assign lk_value   = lk_bus_hit ? res_value : value_mem[lk_tag];

  assign head_live    = live_v[head_idx];
  assign head_done    = done_v[head_idx];
  assign head_kind    = kind_mem[head_idx];
  assign head_dest    = dest_mem[head_idx];
  assign head_pc      = pc_mem[head_idx];
  assign head_value   = value_mem[head_idx];
  assign head_exc     = exc_v[head_idx];
  assign head_cause   = cause_mem[head_idx];
  assign head_mispred = misp_v[head_idx];

  p_stale_result_r4: assert property (@(posedge clk) disable iff (rst)
    (res_valid && !live_v[res_tag] && !(alloc_we && alloc_idx == res_tag))
      |=> !done_v[$past(res_tag)]);

  p_free_complete_r7: assert property (@(posedge clk) disable iff (rst)
    free_we |-> (live_v[head_idx] && done_v[head_idx]));
endmodule

// File: rtl/rob_retire.sv
module rob_retire
  import spec_rob_pkg::*;
#(
  parameter int DEPTH = 8,
  parameter int DW    = 32,
  parameter int AW    = 16,
  parameter int PCW   = 32,
  parameter int CW    = 4,
  localparam int TW   = $clog2(DEPTH)
) (
  input  logic           clk,
  input  logic           rst,
  input  logic [TW-1:0]  head_idx,
  input  logic           head_live,
  input  logic           head_done,
  input  logic [1:0]     head_kind,
  input  logic [AW-1:0]  head_dest,
  input  logic [PCW-1:0] head_pc,
  input  logic [DW-1:0]  head_value,
  input  logic           head_exc,
  input  logic [CW-1:0]  head_cause,
  input  logic           head_mispred,
  output logic           pop,
  output logic           flush_keep,
  output logic           flush_all,
  output logic           cm_valid,
  output logic           cm_reg_we,
  output logic           cm_st_we,
  output logic [TW-1:0]  cm_tag,
  output logic [AW-1:0]  cm_dest,
  output logic [DW-1:0]  cm_data,
  output logic           flush_valid,
  output logic           flush_exc,
  output logic [PCW-1:0] flush_pc,
  output logic [CW-1:0]  flush_cause
);
  op_kind_e kind;
  logic     fire;

  assign kind       = op_kind_e'(head_kind);
  assign fire       = head_live && head_done;
  assign flush_all  = fire && head_exc;
  assign pop        = fire && !head_exc;
  assign flush_keep = pop && (kind == K_BRANCH) && head_mispred;

  always_ff @(posedge clk) begin
    if (rst) begin
      cm_valid    <= 1'b0;
      cm_reg_we   <= 1'b0;
      cm_st_we    <= 1'b0;
      cm_tag      <= '0;
      cm_dest     <= '0;
      cm_data     <= '0;
      flush_valid <= 1'b0;
      flush_exc   <= 1'b0;
      flush_pc    <= '0;
      flush_cause <= '0;
    end else begin
      cm_valid    <= pop;
      cm_reg_we   <= pop && (kind == K_REG);
      cm_st_we    <= pop && (kind == K_STORE);
      cm_tag      <= pop ? head_idx   : '0;
      cm_dest     <= pop ? head_dest  : '0;
      cm_data     <= pop ? head_value : '0;
      flush_valid <= flush_keep || flush_all;
      flush_exc   <= flush_all;
      flush_pc    <= (flush_keep || flush_all) ? head_pc : '0;
      flush_cause <= flush_all ? head_cause : '0;
    end
  end

  p_single_write_r8: assert property (@(posedge clk) disable iff (rst)
    $onehot0({cm_reg_we, cm_st_we}));

  p_write_is_retire_r8: assert property (@(posedge clk) disable iff (rst)
    (cm_reg_we || cm_st_we) |-> cm_valid);

  p_fault_no_write_r11: assert property (@(posedge clk) disable iff (rst)
    flush_exc |-> (!cm_valid && flush_valid));
endmodule

// File: rtl/spec_rob.sv
module spec_rob
  import spec_rob_pkg::*;
#(
  parameter int DEPTH = 8,
  parameter int DW    = 32,
  parameter int AW    = 16,
  parameter int PCW   = 32,
  parameter int CW    = 4,
  localparam int TW   = $clog2(DEPTH),
  localparam int CNTW = $clog2(DEPTH + 1)
) (
  input  logic           clk,
  input  logic           rst,
  input  logic           alloc_valid,
  input  logic [1:0]     alloc_kind,
  input  logic [AW-1:0]  alloc_dest,
  input  logic [PCW-1:0] alloc_pc,
  output logic           alloc_ready,
  output logic [TW-1:0]  alloc_tag,
  input  logic           res_valid,
  input  logic [TW-1:0]  res_tag,
  input  logic [DW-1:0]  res_value,
  input  logic           res_exc,
  input  logic [CW-1:0]  res_cause,
  input  logic           res_mispred,
  input  logic [TW-1:0]  lk_tag,
  output logic           lk_valid,
  output logic [DW-1:0]  lk_value,
  output logic           cm_valid,
  output logic           cm_reg_we,
  output logic           cm_st_we,
  output logic [TW-1:0]  cm_tag,
  output logic [AW-1:0]  cm_dest,
  output logic [DW-1:0]  cm_data,
  output logic           flush_valid,
  output logic           flush_exc,
  output logic [PCW-1:0] flush_pc,
  output logic [CW-1:0]  flush_cause
);
  logic [TW-1:0]   head, tail;
  logic [CNTW-1:0] occupancy;
  logic            full, push, pop, flush_keep, flush_all;
  logic            head_live, head_done, head_exc, head_mispred;
  logic [1:0]      head_kind;
  logic [AW-1:0]   head_dest;
  logic [PCW-1:0]  head_pc;
  logic [DW-1:0]   head_value;
  logic [CW-1:0]   head_cause;

  assign alloc_ready = !full && !flush_keep && !flush_all;
  assign alloc_tag   = tail;
  assign push        = alloc_valid && alloc_ready;

  rob_ptrs #(.DEPTH(DEPTH)) u_ptrs (
    .clk(clk), .rst(rst), .push(push), .pop(pop),
    .flush_keep(flush_keep), .flush_all(flush_all),
    .head(head), .tail(tail), .count(occupancy), .full(full)
  );

  rob_store #(.DEPTH(DEPTH), .DW(DW), .AW(AW), .PCW(PCW), .CW(CW)) u_store (
    .clk(clk), .rst(rst),
    .alloc_we(push), .alloc_idx(tail), .alloc_kind(alloc_kind),
    .alloc_dest(alloc_dest), .alloc_pc(alloc_pc),
    .res_valid(res_valid), .res_tag(res_tag), .res_value(res_value),
    .res_exc(res_exc), .res_cause(res_cause), .res_mispred(res_mispred),
    .kill_all(flush_keep || flush_all), .free_we(pop), .head_idx(head),
    .lk_tag(lk_tag), .lk_valid(lk_valid), .lk_value(lk_value),
    .head_live(head_live), .head_done(head_done), .head_kind(head_kind),
    .head_dest(head_dest), .head_pc(head_pc), .head_value(head_value),
    .head_exc(head_exc), .head_cause(head_cause), .head_mispred(head_mispred)
  );

  rob_retire #(.DEPTH(DEPTH), .DW(DW), .AW(AW), .PCW(PCW), .CW(CW)) u_retire (
    .clk(clk), .rst(rst), .head_idx(head),
    .head_live(head_live), .head_done(head_done), .head_kind(head_kind),
    .head_dest(head_dest), .head_pc(head_pc), .head_value(head_value),
    .head_exc(head_exc), .head_cause(head_cause), .head_mispred(head_mispred),
    .pop(pop), .flush_keep(flush_keep), .flush_all(flush_all),
    .cm_valid(cm_valid), .cm_reg_we(cm_reg_we), .cm_st_we(cm_st_we),
    .cm_tag(cm_tag), .cm_dest(cm_dest), .cm_data(cm_data),
    .flush_valid(flush_valid), .flush_exc(flush_exc),
    .flush_pc(flush_pc), .flush_cause(flush_cause)
  );

  p_flush_empties_r10: assert property (@(posedge clk) disable iff (rst)
    flush_valid |-> (occupancy == '0));

  p_same_edge_r9: assert property (@(posedge clk) disable iff (rst)
    (push && pop && !flush_keep) |=> (occupancy == $past(occupancy)));
endmodule

// File: tb/spec_rob_tb.sv
module spec_rob_tb;
  localparam int RW = 92;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        alloc_valid = 1'b0;
  logic [1:0]  alloc_kind = '0;
  logic [15:0] alloc_dest = '0;
  logic [31:0] alloc_pc = '0;
  logic        alloc_ready;
  logic [2:0]  alloc_tag;
  logic        res_valid = 1'b0;
  logic [2:0]  res_tag = '0;
  logic [31:0] res_value = '0;
  logic        res_exc = 1'b0;
  logic [3:0]  res_cause = '0;
  logic        res_mispred = 1'b0;
  logic [2:0]  lk_tag = '0;
  logic        lk_valid;
  logic [31:0] lk_value;
  logic        cm_valid, cm_reg_we, cm_st_we, flush_valid, flush_exc;
  logic [2:0]  cm_tag;
  logic [15:0] cm_dest;
  logic [31:0] cm_data, flush_pc;
  logic [3:0]  flush_cause;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  typedef struct {
    logic [RW-1:0] rec;
    string         req;
  } exp_t;
  exp_t sb[$];

  always #4 clk = ~clk;

  spec_rob u_dut (
    .clk(clk), .rst(rst), .alloc_valid(alloc_valid), .alloc_kind(alloc_kind),
    .alloc_dest(alloc_dest), .alloc_pc(alloc_pc), .alloc_ready(alloc_ready),
    .alloc_tag(alloc_tag), .res_valid(res_valid), .res_tag(res_tag),
    .res_value(res_value), .res_exc(res_exc), .res_cause(res_cause),
    .res_mispred(res_mispred), .lk_tag(lk_tag), .lk_valid(lk_valid),
    .lk_value(lk_value), .cm_valid(cm_valid), .cm_reg_we(cm_reg_we),
    .cm_st_we(cm_st_we), .cm_tag(cm_tag), .cm_dest(cm_dest), .cm_data(cm_data),
    .flush_valid(flush_valid), .flush_exc(flush_exc), .flush_pc(flush_pc),
    .flush_cause(flush_cause)
  );

  task automatic check(input bit ok, input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic tick();
    @(posedge clk);
    #1;
  endtask

  // retire record: cmv rwe swe tag dest data fv fexc pc cause
  task automatic exp_retire(input logic [2:0] tag, input logic [1:0] k,
                            input logic [15:0] d, input logic [31:0] data,
                            input string req);
    exp_t e;
    e.rec = {1'b1, k == 2'd0, k == 2'd1, tag, d, data, 1'b0, 1'b0, 32'h0, 4'h0};
    e.req = req;
    sb.push_back(e);
  endtask

  task automatic exp_mispred(input logic [2:0] tag, input logic [31:0] pc);
    exp_t e;
    e.rec = {1'b1, 1'b0, 1'b0, tag, 16'h0, 32'h0, 1'b1, 1'b0, pc, 4'h0};
    e.req = "R10";
    sb.push_back(e);
  endtask

  task automatic exp_fault(input logic [31:0] pc, input logic [3:0] cause);
    exp_t e;
    e.rec = {1'b0, 1'b0, 1'b0, 3'h0, 16'h0, 32'h0, 1'b1, 1'b1, pc, cause};
    e.req = "R11";
    sb.push_back(e);
  endtask

  // monitor: pops the scoreboard on every retire or flush report
  always @(negedge clk) begin
    if (!rst && (cm_valid || flush_valid)) begin
      logic [RW-1:0] obs;
      obs = {cm_valid, cm_reg_we, cm_st_we, cm_tag, cm_dest, cm_data,
             flush_valid, flush_exc, flush_pc, flush_cause};
      checks++;
      if (sb.size() == 0) begin
        fails++;
        $display("FAIL R7 unexpected retire: actual %0h expected none", obs);
      end else begin
        exp_t e;
        e = sb.pop_front();
        if (obs !== e.rec) begin
          fails++;
          $display("FAIL %s retire record: actual %0h expected %0h", e.req, obs, e.rec);
        end
      end
    end
  end

  task automatic issue(input logic [1:0] k, input logic [15:0] d,
                       input logic [31:0] pc, input logic [2:0] etag,
                       input string req);
    alloc_valid = 1'b1;
    alloc_kind  = k;
    alloc_dest  = d;
    alloc_pc    = pc;
    @(negedge clk);
    check(alloc_ready === 1'b1, req, "alloc_ready", 32'(alloc_ready), 32'd1);
    check(alloc_tag === etag, req, "alloc_tag", 32'(alloc_tag), 32'(etag));
    tick();
    alloc_valid = 1'b0;
  endtask

  task automatic result(input logic [2:0] t, input logic [31:0] v,
                        input logic e, input logic [3:0] c, input logic m);
    res_valid   = 1'b1;
    res_tag     = t;
    res_value   = v;
    res_exc     = e;
    res_cause   = c;
    res_mispred = m;
    tick();
    res_valid   = 1'b0;
    res_exc     = 1'b0;
    res_mispred = 1'b0;
  endtask

  task automatic expect_lookup(input logic [2:0] t, input logic v,
                               input logic [31:0] val, input string req);
    lk_tag = t;
    @(negedge clk);
    check(lk_valid === v, req, "lk_valid", 32'(lk_valid), 32'(v));
    if (v) check(lk_value === val, req, "lk_value", lk_value, val);
    tick();
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog expired");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    repeat (3) tick();
    rst = 1'b0;
    @(negedge clk);
    // R1 reset state
    check(alloc_ready === 1'b1, "R1", "alloc_ready", 32'(alloc_ready), 32'd1);
    check(alloc_tag === 3'd0, "R1", "alloc_tag", 32'(alloc_tag), 32'd0);
    check(cm_valid === 1'b0, "R1", "cm_valid", 32'(cm_valid), 32'd0);
    check(flush_valid === 1'b0, "R1", "flush_valid", 32'(flush_valid), 32'd0);
    check(lk_valid === 1'b0, "R1", "lk_valid", 32'(lk_valid), 32'd0);
    tick();

    // R2 R7 R8: in-order retire of out-of-order results, all kinds
    exp_retire(3'd0, 2'd0, 16'd5, 32'h1234, "R8");
    exp_retire(3'd1, 2'd1, 16'h40, 32'hAB, "R8");
    exp_retire(3'd2, 2'd2, 16'd0, 32'h0, "R8");
    exp_retire(3'd3, 2'd0, 16'd7, 32'h33, "R7");
    issue(2'd0, 16'd5, 32'h100, 3'd0, "R2");
    issue(2'd1, 16'h40, 32'h104, 3'd1, "R2");
    issue(2'd2, 16'd0, 32'h108, 3'd2, "R2");
    issue(2'd0, 16'd7, 32'h10C, 3'd3, "R2");
    result(3'd3, 32'h33, 1'b0, 4'h0, 1'b0);
    result(3'd2, 32'h0, 1'b0, 4'h0, 1'b0);
    result(3'd1, 32'hAB, 1'b0, 4'h0, 1'b0);
    repeat (3) tick();
    check(sb.size() == 4, "R7", "retired before head complete", 32'(4 - sb.size()), 32'd0);
    result(3'd0, 32'h1234, 1'b0, 4'h0, 1'b0);
    repeat (6) tick();
    check(sb.size() == 0, "R7", "pending retires", 32'(sb.size()), 32'd0);

    // R4 R5 R6: lookup, stale broadcast, same-cycle forwarding
    exp_retire(3'd4, 2'd0, 16'd1, 32'h44, "R6");
    exp_retire(3'd5, 2'd0, 16'd2, 32'h55, "R5");
    issue(2'd0, 16'd1, 32'h110, 3'd4, "R2");
    issue(2'd0, 16'd2, 32'h114, 3'd5, "R2");
    result(3'd6, 32'h66, 1'b0, 4'h0, 1'b0);
    expect_lookup(3'd6, 1'b0, 32'h0, "R4");
    result(3'd5, 32'h55, 1'b0, 4'h0, 1'b0);
    expect_lookup(3'd5, 1'b1, 32'h55, "R4");
    expect_lookup(3'd4, 1'b0, 32'h0, "R5");
    expect_lookup(3'd3, 1'b0, 32'h0, "R5");
    res_valid = 1'b1; res_tag = 3'd4; res_value = 32'h44; lk_tag = 3'd4;
    @(negedge clk);
    check(lk_valid === 1'b1, "R6", "lk_valid bypass", 32'(lk_valid), 32'd1);
    check(lk_value === 32'h44, "R6", "lk_value bypass", lk_value, 32'h44);
    tick();
    res_valid = 1'b0;
    repeat (5) tick();
    check(sb.size() == 0, "R7", "pending retires", 32'(sb.size()), 32'd0);

    // R3 R9: fill, ignored allocs, allocate while retiring
    for (int i = 0; i < 8; i++) begin
      exp_retire(3'(6 + i), 2'd0, 16'(10 + i), 32'h2000 + 32'(i), "R9");
      issue(2'd0, 16'(10 + i), 32'h200 + 32'(4 * i), 3'(6 + i), "R2");
    end
    alloc_valid = 1'b1; alloc_dest = 16'hFF;
    for (int i = 0; i < 2; i++) begin
      @(negedge clk);
      check(alloc_ready === 1'b0, "R3", "alloc_ready when full", 32'(alloc_ready), 32'd0);
      tick();
    end
    alloc_valid = 1'b0;
    for (int i = 1; i < 8; i++) result(3'(6 + i), 32'h2000 + 32'(i), 1'b0, 4'h0, 1'b0);
    result(3'd6, 32'h2000, 1'b0, 4'h0, 1'b0);
    @(negedge clk);
    check(alloc_ready === 1'b0, "R3", "alloc_ready before retire", 32'(alloc_ready), 32'd0);
    tick();
    exp_retire(3'd6, 2'd0, 16'd30, 32'h3000, "R9");
    issue(2'd0, 16'd30, 32'h300, 3'd6, "R3");
    exp_retire(3'd7, 2'd0, 16'd31, 32'h3001, "R9");
    issue(2'd0, 16'd31, 32'h304, 3'd7, "R9");
    repeat (10) tick();
    for (int i = 0; i < 6; i++) begin
      exp_retire(3'(i), 2'd0, 16'(32 + i), 32'h3002 + 32'(i), "R9");
      issue(2'd0, 16'(32 + i), 32'h308 + 32'(4 * i), 3'(i), "R9");
    end
    @(negedge clk);
    check(alloc_ready === 1'b0, "R9", "full after refill", 32'(alloc_ready), 32'd0);
    tick();
    result(3'd6, 32'h3000, 1'b0, 4'h0, 1'b0);
    result(3'd7, 32'h3001, 1'b0, 4'h0, 1'b0);
    for (int i = 0; i < 6; i++) result(3'(i), 32'h3002 + 32'(i), 1'b0, 4'h0, 1'b0);
    repeat (10) tick();
    check(sb.size() == 0, "R9", "pending retires", 32'(sb.size()), 32'd0);

    // R10: mispredicted branch discards younger entries
    exp_retire(3'd6, 2'd0, 16'd3, 32'h77, "R10");
    exp_mispred(3'd7, 32'h500);
    issue(2'd0, 16'd3, 32'h4FC, 3'd6, "R2");
    issue(2'd2, 16'd0, 32'h500, 3'd7, "R2");
    issue(2'd0, 16'd4, 32'h504, 3'd0, "R2");
    issue(2'd1, 16'h80, 32'h508, 3'd1, "R2");
    result(3'd0, 32'hDEAD, 1'b0, 4'h0, 1'b0);
    result(3'd1, 32'hBEEF, 1'b0, 4'h0, 1'b0);
    result(3'd7, 32'h0, 1'b0, 4'h0, 1'b1);
    result(3'd6, 32'h77, 1'b0, 4'h0, 1'b0);
    repeat (6) tick();
    check(sb.size() == 0, "R10", "pending retires", 32'(sb.size()), 32'd0);
    expect_lookup(3'd0, 1'b0, 32'h0, "R10");
    @(negedge clk);
    check(alloc_tag === 3'd0, "R10", "next tag", 32'(alloc_tag), 32'd0);
    tick();

    // R11: fault at head, nothing written, everything discarded
    exp_retire(3'd0, 2'd0, 16'd8, 32'h88, "R11");
    exp_fault(32'h604, 4'h5);
    issue(2'd0, 16'd8, 32'h600, 3'd0, "R2");
    issue(2'd0, 16'd9, 32'h604, 3'd1, "R2");
    issue(2'd0, 16'd11, 32'h608, 3'd2, "R2");
    result(3'd2, 32'h99, 1'b0, 4'h0, 1'b0);
    result(3'd1, 32'h0, 1'b1, 4'h5, 1'b0);
    result(3'd0, 32'h88, 1'b0, 4'h0, 1'b0);
    repeat (6) tick();
    check(sb.size() == 0, "R11", "pending retires", 32'(sb.size()), 32'd0);
    expect_lookup(3'd2, 1'b0, 32'h0, "R11");
    @(negedge clk);
    check(alloc_tag === 3'd1, "R11", "next tag", 32'(alloc_tag), 32'd1);
    check(alloc_ready === 1'b1, "R11", "alloc_ready", 32'(alloc_ready), 32'd1);
    tick();

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule